// File: doc/BRIEF.md
# Host Reset and Watchdog Fault Controller

This block drives two active-low outputs to a host processor: a reset line and a separate watchdog fault line. The reset line is pulled low when the supply first comes up, when a wake event arrives, while a supply-undervoltage flag is raised, and when the software watchdog runs out. Each reset lasts a minimum number of millisecond ticks before it is released.

The watchdog counts prescaled millisecond ticks while the host is out of reset. Software keeps it alive by writing the watchdog register. The SPI decoder turns that write into a one-cycle strobe. If no write arrives within the period, the block starts a new reset pulse. A debug input from the mode sequencer stops the count, so a halted host is not reset.

The fault line goes low in the same cycle as the reset line. It stays low after reset is released and goes high only on the first watchdog write accepted while the host is out of reset. This lets external parts see that the host has not yet refreshed the watchdog.

Top module: `rstwd_ctrl`

## Requirements
- R1: While `rst_n` is low, `host_rst_n` and `wd_fault_n` are both low. After `rst_n` goes high, the block runs a normal power-up reset pulse.
- R2: A `pwr_up` or `wake` strobe drives `host_rst_n` and `wd_fault_n` low on the next clock and restarts the pulse count.
- R3: While `supply_low` is high, `host_rst_n` stays low. The minimum pulse count starts only once the flag has cleared.
- R4: A reset pulse ends on the clock after the PULSE_TICKS-th `tick` cycle that follows the last trigger cycle. A tick in the trigger cycle itself does not count.
- R5: With no watchdog write, `host_rst_n` goes low one clock after the PERIOD_TICKS-th `tick` cycle counted from reset release. With no software activity this repeats indefinitely.
- R6: A `wd_write` accepted while reset is released restarts the period, so the timeout falls PERIOD_TICKS ticks after the write cycle.
- R7: `wd_fault_n` falls together with `host_rst_n`, stays low after reset is released, and rises on the clock after an accepted `wd_write`.
- R8: A `wd_write` while `host_rst_n` is low has no effect: `wd_fault_n` stays low and the period is not shortened.
- R9: While `debug_on` is high, the watchdog neither counts nor times out. When `debug_on` falls, a full period is allowed.
- R10: If any reset cause and `wd_write` occur in the same cycle, the reset cause wins and `wd_fault_n` goes or stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block logic |
| tick | input | 1 | One-cycle strobe per millisecond |
| pwr_up | input | 1 | Power-up event strobe |
| wake | input | 1 | Wake-up event strobe |
| supply_low | input | 1 | Supply-undervoltage level flag |
| wd_write | input | 1 | Decoded write to the watchdog register, one cycle |
| debug_on | input | 1 | Debug mode active; disables the watchdog timeout |
| host_rst_n | output | 1 | Active-low reset to the host |
| wd_fault_n | output | 1 | Active-low watchdog fault indication |

## Verification
Every cause is registered once, so a trigger seen on a clock shows on both outputs one clock later. A pulse releases one clock after the last counted tick. A timeout tick lowers reset one clock later. An accepted write raises the fault line one clock later. The bench drives inputs on the falling edge and steps a behavioural model at the rising edge. It compares both outputs with that model at every falling edge, so each result is checked in the exact cycle it is due and in every cycle around it.

// File: rtl/rstwd_pkg.sv
// Shared types for the host reset and watchdog controller.
// Assumes: all strobes are synchronous to clk and last one cycle.
package rstwd_pkg;

    // Sources that start or hold a host reset pulse.
    typedef struct packed {
        logic pwr;     // power-up event
        logic wake;    // wake-up event
        logic uv;      // supply undervoltage, level
        logic expire;  // watchdog period ran out
    } rst_cause_t;

    // Counter width able to hold values 0..n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rstwd_pulse.sv
// Reset pulse stretcher. Any cycle with trig high holds the pulse
// active and clears the tick count. Once trig is low, the pulse ends
// after PULSE_TICKS tick cycles.
// Assumes: PULSE_TICKS >= 1; a level trigger simply re-arms every cycle.
module rstwd_pulse #(
    parameter int PULSE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trig,
    output logic active
);
    localparam int W = rstwd_pkg::cnt_w(PULSE_TICKS);
    localparam logic [W-1:0] LAST = W'(PULSE_TICKS - 1);

    logic         active_q;
    logic [W-1:0] cnt_q;

    // Pulse state and tick count; block reset behaves as a fresh trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || trig) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q && tick) begin
            if (cnt_q == LAST) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active = active_q;

    // R4
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> ($past(tick) && $past(cnt_q) == LAST));

    // R3
    uv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> active_q);

endmodule

// File: rtl/rstwd_timer.sv
// Watchdog period counter. Counts tick cycles while not held.
// Clear restarts it from zero. expire is high on the tick that
// completes PERIOD_TICKS ticks.
// Assumes: hold covers both host reset and debug mode.
module rstwd_timer #(
    parameter int PERIOD_TICKS = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic clear,
    output logic expire
);
    localparam int W = rstwd_pkg::cnt_w(PERIOD_TICKS);
    localparam logic [W-1:0] LAST = W'(PERIOD_TICKS - 1);

    logic [W-1:0] cnt_q;

    // Expiry when the final tick of the period arrives unheld.
    always_comb begin
        expire = !hold && tick && (cnt_q == LAST);
    end

    // Period counter: cleared on hold or clear, else advances on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(PERIOD_TICKS));

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0));

endmodule

// File: rtl/rstwd_flag.sv
// Fault latch. Set wins over clear. The output is the latched low level.
// Assumes: clr is already qualified by the caller.
module rstwd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic low
);
    logic low_q;

    // Latch fault on set, drop it on clr, reset into the faulted state.
    always_ff @(posedge clk) begin
        if (!rst_n || set) begin
            low_q <= 1'b1;
        end else if (clr) begin
            low_q <= 1'b0;
        end
    end

    assign low = low_q;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> low_q);

endmodule

// File: rtl/rstwd_ctrl.sv
// Host reset and watchdog fault controller (top).
// Combines the reset causes, stretches them into a host reset pulse,
// runs the watchdog period and latches the fault output.
// Assumes: tick, pwr_up, wake and wd_write are one-cycle strobes on clk.
module rstwd_ctrl #(
    parameter int PERIOD_TICKS = 350,
    parameter int PULSE_TICKS  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_up,
    input  logic wake,
    input  logic supply_low,
    input  logic wd_write,
    input  logic debug_on,
    output logic host_rst_n,
    output logic wd_fault_n
);
    import rstwd_pkg::*;

    rst_cause_t cause;
    logic       trig_any;
    logic       rst_active;
    logic       expire;
    logic       wr_ok;
    logic       fault_low;

    // Gather every reset source into one trigger.
    always_comb begin
        cause.pwr    = pwr_up;
        cause.wake   = wake;
        cause.uv     = supply_low;
        cause.expire = expire;
        trig_any     = |cause;
        wr_ok        = wd_write && !rst_active;
    end

    rstwd_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .trig(trig_any), .active(rst_active)
    );

    rstwd_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .hold(rst_active || debug_on), .clear(trig_any || wr_ok),
        .expire(expire)
    );

    rstwd_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(trig_any),
        .clr(wr_ok), .low(fault_low)
    );

    assign host_rst_n = !rst_active;
    assign wd_fault_n = !fault_low;

    // R2
    event_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up || wake) |=> (!host_rst_n && !wd_fault_n));

    // R7
    fault_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rst_n) |-> !wd_fault_n);

    // R8
    write_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_write && !host_rst_n) |=> !wd_fault_n);

    // R6
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_write && host_rst_n && !pwr_up && !wake && !supply_low && !expire)
        |=> wd_fault_n);

endmodule

// File: tb/sim_rstwd_ctrl.sv
module sim_rstwd_ctrl;
    localparam int PER = 350;
    localparam int PUL = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic pwr_up = 1'b0;
    logic wake = 1'b0;
    logic supply_low = 1'b0;
    logic wd_write = 1'b0;
    logic debug_on = 1'b0;
    logic host_rst_n;
    logic wd_fault_n;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_rst = 1, m_pc = 0, m_wd = 0, m_fault = 1;

    rstwd_ctrl #(.PERIOD_TICKS(PER), .PULSE_TICKS(PUL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_up(pwr_up), .wake(wake),
        .supply_low(supply_low), .wd_write(wd_write), .debug_on(debug_on),
        .host_rst_n(host_rst_n), .wd_fault_n(wd_fault_n)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b cycle=%0d", req, what, act, exp, cyc);
        end
    endtask

    // Reference model steps at the rising edge from the sampled inputs.
    always @(posedge clk) begin
        int to, trig;
        cyc++;
        if (!rst_n) begin
            m_rst = 1; m_pc = 0; m_wd = 0; m_fault = 1;
        end else begin
            to   = (m_rst == 0 && !debug_on && tick && m_wd == PER - 1) ? 1 : 0;
            trig = (pwr_up || wake || supply_low || to != 0) ? 1 : 0;
            if (trig != 0) m_fault = 1;
            else if (wd_write && m_rst == 0) m_fault = 0;
            if (m_rst != 0 || debug_on || trig != 0 || wd_write) m_wd = 0;
            else if (tick) m_wd = m_wd + 1;
            if (trig != 0) begin
                m_rst = 1; m_pc = 0;
            end else if (m_rst != 0 && tick) begin
                if (m_pc == PUL - 1) begin m_rst = 0; m_pc = 0; end
                else m_pc = m_pc + 1;
            end
        end
    end

    // Compare both outputs with the model on every falling edge.
    always @(negedge clk) begin
        chk(cur_req, "host_rst_n", host_rst_n, (m_rst != 0) ? 1'b0 : 1'b1);
        chk(cur_req, "wd_fault_n", wd_fault_n, (m_fault != 0) ? 1'b0 : 1'b1);
    end

    // Millisecond tick every fourth clock.
    always @(negedge clk) begin
        tick <= ((cyc % 4) == 0);
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rel();
        int k = 0;
        while (host_rst_n !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_rst();
        int k = 0;
        while (host_rst_n !== 1'b0 && k < 5000) begin @(negedge clk); k++; end
    endtask

    // Watchdog on the run itself.
    initial begin
        step(150000);
        n_run++; n_fail++;
        $display("FAIL watchdog run hung actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        step(6);
        chk("R1", "host_rst_n in reset", host_rst_n, 1'b0);
        chk("R1", "wd_fault_n in reset", wd_fault_n, 1'b0);
        rst_n = 1'b1;
        cur_req = "R4";
        wait_rel();
        cur_req = "R7";
        step(20);
        chk("R7", "fault still low after release", wd_fault_n, 1'b0);
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        chk("R7", "fault released by write", wd_fault_n, 1'b1);
        // R6: restart and let the period run out once
        cur_req = "R6";
        step(700);
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        cur_req = "R5";
        wait_rst();
        chk("R5", "timeout reset", host_rst_n, 1'b0);
        chk("R5", "timeout fault", wd_fault_n, 1'b0);
        // R8: write during reset ignored
        cur_req = "R8";
        step(3);
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        chk("R8", "write in reset ignored", wd_fault_n, 1'b0);
        wait_rel();
        step(2);
        chk("R8", "fault low after release", wd_fault_n, 1'b0);
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        // R9: debug freezes the watchdog
        cur_req = "R9";
        debug_on = 1'b1;
        step(PER * 4 * 2);
        chk("R9", "no timeout in debug", host_rst_n, 1'b1);
        debug_on = 1'b0;
        step(PER * 4 - 20);
        chk("R9", "full period after debug", host_rst_n, 1'b1);
        wait_rst();
        wait_rel();
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        // R2: wake and power-up events
        cur_req = "R2";
        step(37);
        wake = 1'b1; step(1); wake = 1'b0;
        chk("R2", "wake reset", host_rst_n, 1'b0);
        wait_rel();
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        step(11);
        pwr_up = 1'b1; step(1); pwr_up = 1'b0;
        chk("R2", "power-up fault", wd_fault_n, 1'b0);
        step(17);
        pwr_up = 1'b1; step(1); pwr_up = 1'b0;
        wait_rel();
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        // R3: undervoltage holds reset
        cur_req = "R3";
        step(9);
        supply_low = 1'b1;
        step(90);
        chk("R3", "reset held by undervoltage", host_rst_n, 1'b0);
        supply_low = 1'b0;
        step(PUL * 4 - 8);
        chk("R3", "still in pulse after flag clears", host_rst_n, 1'b0);
        wait_rel();
        wd_write = 1'b1; step(1); wd_write = 1'b0;
        // R10: trigger and write together
        cur_req = "R10";
        step(5);
        wake = 1'b1; wd_write = 1'b1; step(1); wake = 1'b0; wd_write = 1'b0;
        chk("R10", "trigger beats write", wd_fault_n, 1'b0);
        wait_rel();
        step(30);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule